// File: doc/BRIEF.md
# Strobe-to-FIFO Access Controller

This controller connects two asynchronous strobe sources to a synchronous FIFO of 8192 words by 16 bits. A host on a microcontroller-style bus reads samples by pulling a chip-select and a read strobe low together. Each such access produces exactly one single-clock pop pulse, and the FIFO read word is presented on the host data bus through an output enable that is meant to drive a tri-state pad. An acquisition front end stores samples by pulling its write strobe low. Each such assertion produces exactly one single-clock push pulse that carries the current 16-bit sample into the FIFO.

Both strobes pass through a two-flop synchroniser before any pulse logic. The read pulse rises one clock after the synchronised read request and the write pulse two clocks after it, which gives the FIFO a fixed setup margin. The FIFO side is a push/pop interface in which the FIFO's empty and full flags act as back-pressure. A pop is dropped when the FIFO is empty on the edge that would raise it, and a push is dropped when it is full. A dropped pulse still uses up its strobe assertion, so no retry follows. The FIFO array and its flag logic sit outside this block.

Top module: `fifo_strobe_ctrl`

## Requirements
- R1: In the clock cycle after an active-high synchronous reset, `fifo_pop` and `fifo_push` are low, and neither pulses until a strobe is newly seen after reset.
- R2: A read happens only when `sel_n` and `rd_n` are both low. With only one of them low, `fifo_pop` stays low and `bus_oe` stays low.
- R3: When `sel_n` and `rd_n` go low together between clock edges, `fifo_pop` is high for exactly one cycle. It rises on the third rising edge after that change and falls on the fourth, which is one edge after the synchronised request rises.
- R4: When `wr_n` goes low between clock edges, `fifo_push` is high for exactly one cycle. It rises on the fourth rising edge after that change and falls on the fifth, which is two edges after the synchronised request rises.
- R5: Holding a strobe low for any number of cycles gives one pulse only. A further pulse needs the strobe to be released across at least one clock edge.
- R6: `bus_oe` is high exactly while `sel_n` and `rd_n` are both low, with no clock delay. While it is high, `bus_rdata` equals `fifo_rdata`; otherwise `bus_rdata` is zero.
- R7: When `fifo_empty` is high on the edge that would raise `fifo_pop`, no pop pulse is issued for that read access.
- R8: When `fifo_full` is high on the edge that would raise `fifo_push`, no push pulse is issued for that write access.
- R9: `fifo_wdata` always equals `sample_data` in the same cycle, so the word stored by a push is the sample present during the push cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high synchronous reset |
| sel_n | input | 1 | Host chip-select, active low, asynchronous |
| rd_n | input | 1 | Host read strobe, active low, asynchronous |
| wr_n | input | 1 | Front-end write strobe, active low, asynchronous |
| sample_data | input | 16 | Sampled word from the front end |
| fifo_rdata | input | 16 | Word currently presented by the FIFO |
| fifo_empty | input | 1 | FIFO holds no words |
| fifo_full | input | 1 | FIFO holds 8192 words |
| fifo_pop | output | 1 | One-cycle read pulse to the FIFO |
| fifo_push | output | 1 | One-cycle write pulse to the FIFO |
| fifo_wdata | output | 16 | Word written on a push |
| bus_rdata | output | 16 | Data toward the host bus pad |
| bus_oe | output | 1 | Output enable for the host bus tri-state pad |

## Verification
A sequencer stuck outside its idle state shows up at the next strobe as a missing pulse. A sequencer that fails to wait for release shows up as a second pop or push a few cycles into a long strobe hold. An off-by-one in the synchroniser or the lead counter moves the pulse by a whole cycle, and that shows in the first access after reset, because every access is sampled at each cycle from its start. An empty or full flag sampled at the wrong edge shows up as a pulse that should have been dropped, in the same access.

// File: rtl/fifo_strobe_pkg.sv
package fifo_strobe_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WAIT = 2'd1,
    SEQ_HOLD = 2'd2
  } seq_state_t;
endpackage

// File: rtl/fifo_strobe_sync.sv
module fifo_strobe_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/fifo_strobe_seq.sv
module fifo_strobe_seq
  import fifo_strobe_pkg::*;
#(
  parameter int LEAD = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic blocked,
  output logic pulse
);
  localparam int CW = (LEAD > 1) ? $clog2(LEAD) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'((LEAD > 0) ? LEAD - 1 : 0);

  seq_state_t      state_q;
  logic [CW-1:0]   cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      pulse   <= 1'b0;
    end else begin
      pulse <= 1'b0;
      case (state_q)
        SEQ_IDLE: begin
          if (req) begin
            if (LEAD == 0) begin
              pulse   <= ~blocked;
              state_q <= SEQ_HOLD;
            end else begin
              cnt_q   <= CNT_LOAD;
              state_q <= SEQ_WAIT;
            end
          end
        end
        SEQ_WAIT: begin
          if (cnt_q == '0) begin
            pulse   <= ~blocked;
            state_q <= SEQ_HOLD;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        SEQ_HOLD: begin
          if (!req) state_q <= SEQ_IDLE;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  // R3 / R4: every pulse lasts exactly one cycle
  a_r3_single_cycle: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);

  // R5: a strobe still held after its pulse never fires again
  a_r5_no_repeat: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEQ_HOLD && req) |=> !pulse);
endmodule

// File: rtl/fifo_strobe_ctrl.sv
module fifo_strobe_ctrl #(
  parameter int DATA_W    = 16,
  parameter int SYNC_DEPTH = 2,
  parameter int RD_LEAD   = 0,
  parameter int WR_LEAD   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] sample_data,
  input  logic [DATA_W-1:0] fifo_rdata,
  input  logic              fifo_empty,
  input  logic              fifo_full,
  output logic              fifo_pop,
  output logic              fifo_push,
  output logic [DATA_W-1:0] fifo_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_oe
);
  logic       rd_access;
  logic [1:0] req_sync;
  logic       rd_sync;
  logic       wr_sync;

  assign rd_access = ~sel_n & ~rd_n;

  fifo_strobe_sync #(.WIDTH(2), .STAGES(SYNC_DEPTH)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in ({~wr_n, rd_access}),
    .sync_out (req_sync)
  );

  assign rd_sync = req_sync[0];
  assign wr_sync = req_sync[1];

  fifo_strobe_seq #(.LEAD(RD_LEAD)) u_rd_seq (
    .clk     (clk),
    .rst     (rst),
    .req     (rd_sync),
    .blocked (fifo_empty),
    .pulse   (fifo_pop)
  );

  fifo_strobe_seq #(.LEAD(WR_LEAD)) u_wr_seq (
    .clk     (clk),
    .rst     (rst),
    .req     (wr_sync),
    .blocked (fifo_full),
    .pulse   (fifo_push)
  );

  assign bus_oe     = rd_access;
  assign bus_rdata  = rd_access ? fifo_rdata : '0;
  assign fifo_wdata = sample_data;

  // R1: nothing pulses right after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!fifo_pop && !fifo_push));

  // R3: a pop is always preceded by a synchronised read request
  a_r3_pop_after_sync: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> $past(rd_sync));

  // R4: a push follows the synchronised write request by two edges
  a_r4_push_after_sync: assert property (@(posedge clk) disable iff (rst)
    fifo_push |-> $past(wr_sync, 2));

  // R7: never pop an empty FIFO
  a_r7_no_pop_empty: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> !$past(fifo_empty));

  // R8: never push a full FIFO
  a_r8_no_push_full: assert property (@(posedge clk) disable iff (rst)
    fifo_push |-> !$past(fifo_full));
endmodule

// File: tb/test_fifo_strobe_ctrl.sv
`timescale 1ns/1ps
module test_fifo_strobe_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [15:0] sample_data = '0, fifo_rdata = '0;
  logic        fifo_empty = 1'b0, fifo_full = 1'b0;
  logic        fifo_pop, fifo_push, bus_oe;
  logic [15:0] fifo_wdata, bus_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fifo_strobe_ctrl i_fifo_strobe_ctrl (
    .clk(clk), .rst(rst), .sel_n(sel_n), .rd_n(rd_n), .wr_n(wr_n),
    .sample_data(sample_data), .fifo_rdata(fifo_rdata),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .fifo_pop(fifo_pop), .fifo_push(fifo_push), .fifo_wdata(fifo_wdata),
    .bus_rdata(bus_rdata), .bus_oe(bus_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_pulse(input bit en, input int i, input int at, input bit blk);
    return en && !blk && (i == at);
  endfunction

  // rk: 0 idle, 1 full read access, 2 select only, 3 read strobe only
  task automatic run_case(input int rk, input bit wr, input bit emp, input bit ful, input int hold);
    bit rd_ok;
    @(negedge clk);
    fifo_empty = emp;
    fifo_full  = ful;
    @(negedge clk);
    sel_n = !(rk == 1 || rk == 2);
    rd_n  = !(rk == 1 || rk == 3);
    wr_n  = !wr;
    fifo_rdata  = 16'($urandom);
    sample_data = 16'($urandom);
    rd_ok = (rk == 1);
    #0.1;
    chk(bus_oe == rd_ok, "R6 oe immediate", bus_oe, rd_ok);
    for (int i = 1; i <= hold; i++) begin
      @(negedge clk);
      // R3 R7 R2 R5: pop timing and suppression
      chk(fifo_pop == exp_pulse(rd_ok, i, 3, emp), "R3 pop", fifo_pop, exp_pulse(rd_ok, i, 3, emp));
      // R4 R8 R5: push timing and suppression
      chk(fifo_push == exp_pulse(wr, i, 4, ful), "R4 push", fifo_push, exp_pulse(wr, i, 4, ful));
      chk(bus_oe == rd_ok, "R2 oe", bus_oe, rd_ok);
      chk(bus_rdata == (rd_ok ? fifo_rdata : 16'h0), "R6 bus data", bus_rdata, rd_ok ? fifo_rdata : 0);
      chk(fifo_wdata == sample_data, "R9 wdata", fifo_wdata, sample_data);
    end
    sel_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      chk(!fifo_pop && !fifo_push, "R5 quiet after release", {fifo_pop, fifo_push}, 0);
      chk(!bus_oe && bus_rdata == 0, "R6 released bus", bus_oe, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!fifo_pop && !fifo_push, "R1 reset state", {fifo_pop, fifo_push}, 0);
    chk(!bus_oe, "R1 oe idle", bus_oe, 0);
    // directed corner cases
    run_case(1, 1'b1, 1'b0, 1'b0, 6);   // R3 R4 basic
    run_case(1, 1'b1, 1'b0, 1'b0, 20);  // R5 long hold
    run_case(1, 1'b0, 1'b1, 1'b0, 7);   // R7 empty
    run_case(0, 1'b1, 1'b0, 1'b1, 7);   // R8 full
    run_case(2, 1'b0, 1'b0, 1'b0, 6);   // R2 select only
    run_case(3, 1'b0, 1'b0, 1'b0, 6);   // R2 read only
    run_case(1, 1'b0, 1'b0, 1'b0, 5);   // R3 read alone
    run_case(0, 1'b1, 1'b0, 1'b0, 5);   // R4 write alone
    // constrained random
    for (int n = 0; n < 80; n++) begin
      run_case(int'($urandom_range(3, 0)), 1'($urandom_range(1, 0)),
               1'($urandom_range(3, 0) == 0), 1'($urandom_range(3, 0) == 0),
               int'($urandom_range(12, 5)));
    end
    // R1: reset during a held strobe suppresses the pending pulse
    @(negedge clk);
    fifo_empty = 0; fifo_full = 0;
    sel_n = 0; rd_n = 0; wr_n = 0;
    @(negedge clk);
    rst = 1'b1;
    sel_n = 1; rd_n = 1; wr_n = 1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!fifo_pop && !fifo_push, "R1 no pulse after reset", {fifo_pop, fifo_push}, 0);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule